// File: doc/BRIEF.md
# Dual-Convention Stack Engine

This block owns a stack pointer and turns push and pop requests into a sequence of single-byte accesses on a byte-wide memory port. A request carries a direction (push or pop), a width (one byte or a two-byte word) and, for pushes, the data. Words are kept big-endian in memory. The more significant byte sits at the lower address and is moved in the first byte cycle. Popped data is returned on a result bus together with a one-cycle completion pulse.

Two stack conventions are selected per request by a mode input. In the next-available convention the stack pointer names the free byte just below the stack. In the last-used convention it names the byte on top of the stack. The two conventions differ in where the first byte access lands and in whether the pointer moves before or after the access. The final pointer is the same in both: it drops by the access size on a push and rises by it on a pop.

A memory error response in any byte cycle ends the operation at once. The stack pointer keeps its old value and an error flag is raised. The pointer can also be written directly through a load port while the engine is idle.

Top module: `stack_engine`

## Requirements
- R1: During and straight after reset, sp is 0, and busy, done, err, mem_en and every bit of rd_data are 0.
- R2: With mode_last_used = 0 (next-available): a byte push writes at SP and leaves SP-1; a word push writes SP-1 then SP and leaves SP-2; a byte pop reads SP+1 and leaves SP+1; a word pop reads SP+1 then SP+2 and leaves SP+2.
- R3: With mode_last_used = 1 (last-used): a byte push writes at SP-1 and leaves SP-1; a word push writes SP-2 then SP-1 and leaves SP-2; a byte pop reads SP and leaves SP+1; a word pop reads SP then SP+1 and leaves SP+2. All address arithmetic wraps modulo 2^16.
- R4: A word access uses two consecutive byte cycles. The first cycle goes to the lower address and carries the high byte, req_data[15:8]. The second goes to the lower address plus one and carries the low byte.
- R5: A request is taken when req_valid is 1, req_pop selects pop (1) or push (0), req_wide selects word (1) or byte (0), busy is 0 and sp_load is 0. From the next cycle, busy is 1 for one cycle per byte, with mem_en set in each. done is then 1 for exactly one cycle with busy at 0. In that same cycle sp shows its new value.
- R6: If mem_err is 1 in a byte cycle, the operation stops with no further byte cycles. In the following cycle done and err are both 1, sp keeps its value from before the request, and rd_data is unchanged.
- R7: req_valid and sp_load are ignored while busy is 1: no extra operation and no change to sp.
- R8: sp_load while idle puts sp_load_val on sp in the next cycle. When sp_load and req_valid are 1 in the same idle cycle, the load wins and the request is dropped.
- R9: A successful byte pop returns the byte zero-extended in rd_data[7:0]. A successful word pop returns {first byte, second byte}. A push leaves rd_data unchanged.
- R10: err holds its value until the next request is taken, and is 0 from the first byte cycle of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_last_used | input | 1 | 0 = next-available convention, 1 = last-used convention; sampled with the request |
| req_valid | input | 1 | Request strobe |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_wide | input | 1 | 1 = 16-bit word, 0 = byte |
| req_data | input | 16 | Push data; for a byte push only [7:0] is used |
| sp_load | input | 1 | Direct stack pointer write strobe |
| sp_load_val | input | 16 | Value for the direct write |
| mem_en | output | 1 | Byte access active this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the same cycle as mem_en |
| mem_err | input | 1 | Error response for the current byte access |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse, also raised on an abort |
| rd_data | output | 16 | Data from the last successful pop |
| err | output | 1 | Last operation was stopped by a memory error |
| sp | output | 16 | Current stack pointer |

## Verification
The bench targets the word push in each mode, where the first address is SP-1 in one convention and SP-2 in the other. A design that swapped the two would shift the stacked data by one byte, and the bench would read back corrupted words. It wraps the pointer through zero in the last-used mode, to catch a carry dropped in the address arithmetic. It injects an error on the second byte of a word push and checks that the pointer has not moved. It then checks that the flag clears when the next request is taken, so a sticky or forgotten flag shows up. It drives a request and a pointer load into the middle of a busy operation, and also a load alongside a request in the same idle cycle. A design that let either one through would end with the wrong pointer, or would raise a second done pulse.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_SECOND = 2'd2
  } stk_state_e;

  typedef struct packed {
    logic last_used;
    logic pop;
    logic wide;
  } stk_op_t;

endpackage

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
  import stk_pkg::*;
#(
  parameter int AW = 16
) (
  input  stk_op_t       op,
  input  logic [AW-1:0] sp_cur,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] sp_after
);

  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [AW-1:0] step;

  always_comb begin
    step = op.wide ? TWO : ONE;
    if (op.pop) sp_after = sp_cur + step;
    else        sp_after = sp_cur - step;
  end

  // Where the first byte of the access lands depends on the convention:
  // pre-decrement / post-increment for last-used, the reverse otherwise.
  always_comb begin
    if (op.last_used) begin
      if (op.pop) first_addr = sp_cur;
      else        first_addr = sp_cur - step;
    end else begin
      if (op.pop)      first_addr = sp_cur + ONE;
      else if (op.wide) first_addr = sp_cur - ONE;
      else             first_addr = sp_cur;
    end
  end

endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_val,
  output logic [AW-1:0] sp_q
);

  logic          sp_en;
  logic [AW-1:0] sp_d;

  always_comb begin
    sp_en = load_en | upd_en;
    sp_d  = upd_en ? upd_val : load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  stk_op_t         op_in,
  input  logic [2*BW-1:0] wdata_in,
  input  logic [AW-1:0]   addr_in,
  input  logic [AW-1:0]   sp_after_in,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata,
  input  logic            mem_err,
  output logic            busy,
  output logic            done,
  output logic [2*BW-1:0] rd_data,
  output logic            err,
  output logic            sp_upd_en,
  output logic [AW-1:0]   sp_upd_val
);

  localparam int DW = 2 * BW;

  stk_state_e      state_q, state_d;
  stk_op_t         op_q;
  logic [DW-1:0]   wdat_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   spn_q;
  logic [BW-1:0]   hi_q, hi_d;
  logic            hi_en;
  logic [DW-1:0]   rd_q, rd_d;
  logic            rd_en;
  logic            done_q, done_d;
  logic            err_q, err_d;
  logic            err_en;

  // next-state process
  always_comb begin
    state_d    = state_q;
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    mem_wdata  = '0;
    hi_en      = 1'b0;
    hi_d       = mem_rdata;
    rd_en      = 1'b0;
    rd_d       = rd_q;
    done_d     = 1'b0;
    err_en     = 1'b0;
    err_d      = err_q;
    sp_upd_en  = 1'b0;
    sp_upd_val = spn_q;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_FIRST;
          err_en  = 1'b1;
          err_d   = 1'b0;
        end
      end
      ST_FIRST: begin
        mem_en    = 1'b1;
        mem_we    = ~op_q.pop;
        mem_addr  = addr_q;
        mem_wdata = op_q.wide ? wdat_q[DW-1:BW] : wdat_q[BW-1:0];
        if (mem_err) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_en  = 1'b1;
          err_d   = 1'b1;
        end else if (op_q.wide) begin
          state_d = ST_SECOND;
          hi_en   = 1'b1;
        end else begin
          state_d   = ST_IDLE;
          done_d    = 1'b1;
          sp_upd_en = 1'b1;
          rd_en     = op_q.pop;
          rd_d      = {{BW{1'b0}}, mem_rdata};
        end
      end
      ST_SECOND: begin
        mem_en    = 1'b1;
        mem_we    = ~op_q.pop;
        mem_addr  = addr_q + AW'(1);
        mem_wdata = wdat_q[BW-1:0];
        state_d   = ST_IDLE;
        done_d    = 1'b1;
        if (mem_err) begin
          err_en = 1'b1;
          err_d  = 1'b1;
        end else begin
          sp_upd_en = 1'b1;
          rd_en     = op_q.pop;
          rd_d      = {hi_q, mem_rdata};
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      wdat_q  <= '0;
      addr_q  <= '0;
      spn_q   <= '0;
      hi_q    <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept && state_q == ST_IDLE) begin
        op_q   <= op_in;
        wdat_q <= wdata_in;
        addr_q <= addr_in;
        spn_q  <= sp_after_in;
      end
      if (hi_en)  hi_q  <= hi_d;
      if (rd_en)  rd_q  <= rd_d;
      if (err_en) err_q <= err_d;
    end
  end

  always_comb begin
    busy    = (state_q != ST_IDLE);
    done    = done_q;
    rd_data = rd_q;
    err     = err_q;
  end

endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_last_used,
  input  logic            req_valid,
  input  logic            req_pop,
  input  logic            req_wide,
  input  logic [2*BW-1:0] req_data,
  input  logic            sp_load,
  input  logic [AW-1:0]   sp_load_val,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata,
  input  logic            mem_err,
  output logic            busy,
  output logic            done,
  output logic [2*BW-1:0] rd_data,
  output logic            err,
  output logic [AW-1:0]   sp
);

  stk_op_t       op_in;
  logic          accept;
  logic          load_ok;
  logic [AW-1:0] first_addr;
  logic [AW-1:0] sp_after;
  logic          sp_upd_en;
  logic [AW-1:0] sp_upd_val;

  always_comb begin
    op_in.last_used = mode_last_used;
    op_in.pop       = req_pop;
    op_in.wide      = req_wide;
    load_ok         = sp_load & ~busy;
    accept          = req_valid & ~busy & ~sp_load;
  end

  stk_addr_gen #(.AW(AW)) u_addr (
    .op         (op_in),
    .sp_cur     (sp),
    .first_addr (first_addr),
    .sp_after   (sp_after)
  );

  stk_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .op_in       (op_in),
    .wdata_in    (req_data),
    .addr_in     (first_addr),
    .sp_after_in (sp_after),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_err     (mem_err),
    .busy        (busy),
    .done        (done),
    .rd_data     (rd_data),
    .err         (err),
    .sp_upd_en   (sp_upd_en),
    .sp_upd_val  (sp_upd_val)
  );

  stk_sp_reg #(.AW(AW)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_ok),
    .load_val (sp_load_val),
    .upd_en   (sp_upd_en),
    .upd_val  (sp_upd_val),
    .sp_q     (sp)
  );

endmodule

// File: rtl/stack_engine_chk.sv
module stack_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          sp_load,
  input logic          mem_en,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] sp
);

  // R7 / R8: sp moves only at completion or after an idle load
  p_sp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> (done || ($past(sp_load) && !$past(busy))));

  // R6: an aborted operation leaves sp untouched
  p_abort_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $stable(sp));

  // R2 / R3: a successful operation moves sp by one or two
  p_sp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((sp == $past(sp) + AW'(1)) || (sp == $past(sp) - AW'(1)) ||
                        (sp == $past(sp) + AW'(2)) || (sp == $past(sp) - AW'(2))));

  // R5: done is a single-cycle pulse with busy low
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4: back-to-back byte cycles walk up by one address
  p_addr_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

endmodule

bind stack_engine stack_engine_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .sp_load  (sp_load),
  .mem_en   (mem_en),
  .mem_addr (mem_addr),
  .sp       (sp)
);

// File: tb/stack_engine_tb.sv
module stack_engine_tb;

  logic        clk;
  logic        rst_n;
  logic        mode_last_used;
  logic        req_valid;
  logic        req_pop;
  logic        req_wide;
  logic [15:0] req_data;
  logic        sp_load;
  logic [15:0] sp_load_val;
  logic        mem_en;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_err;
  logic        busy;
  logic        done;
  logic [15:0] rd_data;
  logic        err;
  logic [15:0] sp;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0]  mem   [0:255];
  logic [7:0]  ref_m [0:255];
  logic [15:0] exp_sp;
  logic [15:0] exp_rd;
  logic        inj_en;
  logic [15:0] inj_addr;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  stack_engine u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_last_used (mode_last_used),
    .req_valid      (req_valid),
    .req_pop        (req_pop),
    .req_wide       (req_wide),
    .req_data       (req_data),
    .sp_load        (sp_load),
    .sp_load_val    (sp_load_val),
    .mem_en         (mem_en),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_rdata      (mem_rdata),
    .mem_err        (mem_err),
    .busy           (busy),
    .done           (done),
    .rd_data        (rd_data),
    .err            (err),
    .sp             (sp)
  );

  // byte memory model, same-cycle response, 256 bytes mirrored
  always_comb begin
    mem_rdata = mem[mem_addr[7:0]];
    mem_err   = inj_en && mem_en && (mem_addr == inj_addr);
  end

  always @(posedge clk) begin
    if (mem_en && mem_we && !mem_err) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] f_base(input bit lu, input bit pop, input bit wide,
                                         input logic [15:0] s);
    if (!lu) begin
      if (pop)       return s + 16'd1;
      else if (wide) return s - 16'd1;
      else           return s;
    end else begin
      if (pop)       return s;
      else if (wide) return s - 16'd2;
      else           return s - 16'd1;
    end
  endfunction

  function automatic logic [15:0] f_newsp(input bit pop, input bit wide,
                                          input logic [15:0] s);
    logic [15:0] n;
    n = wide ? 16'd2 : 16'd1;
    return pop ? s + n : s - n;
  endfunction

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = v;
    @(negedge clk);
    sp_load = 1'b0;
    exp_sp = v;
    chk(sp == v, "R8 load", sp, v);
  endtask

  // fault: 0 none, 1 on first byte, 2 on second byte (word only)
  task automatic run_op(input bit lu, input bit pop, input bit wide,
                        input logic [15:0] d, input int fault, input string tag);
    logic [15:0] base, nsp, first_a, exp_val;
    int nb, cyc, fidx, exp_cyc;
    bit saw_idle_busy;
    base = f_base(lu, pop, wide, exp_sp);
    nsp  = f_newsp(pop, wide, exp_sp);
    nb   = wide ? 2 : 1;
    fidx = (fault == 0) ? nb : ((fault == 2 && wide) ? 1 : 0);
    inj_en   = (fault != 0);
    inj_addr = base + 16'(fidx);
    @(negedge clk);
    mode_last_used = lu; req_pop = pop; req_wide = wide; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    first_a = mem_addr;
    saw_idle_busy = !busy;
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
      if (!done && !busy) saw_idle_busy = 1'b1;
    end
    inj_en = 1'b0;
    exp_cyc = (fault != 0) ? fidx + 2 : nb + 1;
    chk(cyc == exp_cyc, {tag, " R5 latency"}, cyc, exp_cyc);
    chk(!saw_idle_busy && !busy, {tag, " R5 busy"}, busy, 0);
    chk(first_a == base, {tag, " R4 first addr"}, first_a, base);
    if (fault != 0) begin
      chk(err == 1'b1, {tag, " R6 err"}, err, 1);
      chk(sp == exp_sp, {tag, " R6 sp kept"}, sp, exp_sp);
      chk(rd_data == exp_rd, {tag, " R6 rd kept"}, rd_data, exp_rd);
    end else begin
      chk(err == 1'b0, {tag, " R10 err clear"}, err, 0);
      chk(sp == nsp, {tag, " sp R2/R3"}, sp, nsp);
      if (pop) begin
        exp_val = wide ? {ref_m[base[7:0]], ref_m[8'(base[7:0] + 8'd1)]}
                       : {8'h00, ref_m[base[7:0]]};
        exp_rd = exp_val;
        chk(rd_data == exp_val, {tag, " R9 pop data"}, rd_data, exp_val);
      end else begin
        chk(rd_data == exp_rd, {tag, " R9 push keeps rd"}, rd_data, exp_rd);
      end
      exp_sp = nsp;
    end
    if (!pop) begin
      for (int i = 0; i < fidx; i++) begin
        ref_m[8'(base[7:0] + 8'(i))] = wide ? (i == 0 ? d[15:8] : d[7:0]) : d[7:0];
      end
      for (int i = 0; i < nb; i++) begin
        logic [7:0] a;
        a = 8'(base[7:0] + 8'(i));
        chk(mem[a] == ref_m[a], {tag, " R4 byte order"}, mem[a], ref_m[a]);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_m[i] = 8'(i * 7 + 3);
    end
    rst_n = 1'b0; mode_last_used = 1'b0; req_valid = 1'b0; req_pop = 1'b0;
    req_wide = 1'b0; req_data = '0; sp_load = 1'b0; sp_load_val = '0;
    inj_en = 1'b0; inj_addr = '0; exp_sp = '0; exp_rd = '0;
    repeat (3) @(negedge clk);
    chk(sp == 0 && !busy && !done && !err && rd_data == 0 && !mem_en,
        "R1 in reset", {sp, rd_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp == 0 && !busy && !done && !err && rd_data == 0 && !mem_en,
        "R1 after reset", {sp, rd_data}, 0);

    // next-available mode
    load_sp(16'h0080);
    run_op(0, 0, 0, 16'h00A5, 0, "R2 na push8");
    run_op(0, 0, 1, 16'h1234, 0, "R2 na push16");
    chk(mem[8'h7E] == 8'h12 && mem[8'h7F] == 8'h34, "R4 na big-endian",
        {mem[8'h7E], mem[8'h7F]}, 16'h1234);
    run_op(0, 1, 1, 16'h0000, 0, "R2 na pop16");
    run_op(0, 1, 0, 16'h0000, 0, "R2 na pop8");

    // last-used mode, with wrap through zero
    load_sp(16'h0000);
    run_op(1, 0, 1, 16'hCAFE, 0, "R3 lu push16 wrap");
    chk(mem[8'hFE] == 8'hCA && mem[8'hFF] == 8'hFE, "R4 lu big-endian",
        {mem[8'hFE], mem[8'hFF]}, 16'hCAFE);
    run_op(1, 0, 0, 16'h005A, 0, "R3 lu push8");
    run_op(1, 1, 0, 16'h0000, 0, "R3 lu pop8");
    run_op(1, 1, 1, 16'h0000, 0, "R3 lu pop16 wrap");

    // error on second byte of a word push, then clear
    load_sp(16'h0040);
    run_op(0, 0, 1, 16'h7788, 2, "R6 err second");
    run_op(1, 1, 1, 16'h0000, 1, "R6 err first");
    run_op(0, 0, 0, 16'h0011, 0, "R10 next op");

    // request and load while busy are ignored
    load_sp(16'h0030);
    begin
      int extra;
      @(negedge clk);
      mode_last_used = 0; req_pop = 0; req_wide = 1; req_data = 16'hBEEF; req_valid = 1;
      @(negedge clk);
      req_pop = 1; sp_load = 1; sp_load_val = 16'h0010;
      @(negedge clk);
      req_valid = 0; sp_load = 0;
      while (!done) @(negedge clk);
      ref_m[8'h2F] = 8'hBE; ref_m[8'h30] = 8'hEF; exp_sp = 16'h002E;
      chk(sp == 16'h002E, "R7 sp after busy inputs", sp, 16'h002E);
      extra = 0;
      repeat (4) begin @(negedge clk); if (done || busy) extra++; end
      chk(extra == 0 && sp == 16'h002E, "R7 no extra op", extra, 0);
    end

    // load beats simultaneous request
    begin
      int extra;
      @(negedge clk);
      sp_load = 1; sp_load_val = 16'h0055; req_valid = 1; req_pop = 0; req_wide = 0;
      @(negedge clk);
      sp_load = 0; req_valid = 0;
      exp_sp = 16'h0055;
      chk(sp == 16'h0055 && !busy, "R8 load priority", sp, 16'h0055);
      extra = 0;
      repeat (3) begin @(negedge clk); if (done || busy) extra++; end
      chk(extra == 0, "R8 request dropped", extra, 0);
    end

    // constrained random
    void'($urandom(32'd1234));
    for (int k = 0; k < 250; k++) begin
      bit lu, pp, wd;
      int flt;
      lu = 1'($urandom_range(0, 1));
      pp = 1'($urandom_range(0, 1));
      wd = 1'($urandom_range(0, 1));
      flt = ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 2)) : 0;
      if ($urandom_range(0, 19) == 0) load_sp(16'($urandom()));
      run_op(lu, pp, wd, 16'($urandom()), flt, lu ? "R3 rand" : "R2 rand");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule